// File: doc/BRIEF.md
# Set-Associative TLB Test Port

This block is a four-way set-associative translation lookaside buffer reached through two 32-bit registers: a command register and a data register. Software first loads the data register with a physical page number and page attributes. It then writes the command register with a linear page address, a valid flag and an operation bit. The write to the command register starts the operation. A test write stores the entry into one way of the indexed set. A test lookup searches that set and places the result back into the data register.

Each set keeps a three-bit tree pseudo-LRU. The way that a test write fills comes from one of two sources. One source is the replacement logic, which takes the first invalid way and otherwise follows the tree. The other is an explicit two-bit pointer held in the data register. A write always makes the filled way the most recently used, and so does a lookup that hits. The low bits of the data register act as the pointer and source select on writes, and as the hit flag and hit way after lookups.

Sequencing is a three-state machine. In ST_IDLE, a command write moves the machine to ST_WRITE when the operation bit is 0, or to ST_LOOKUP when it is 1. Both ST_WRITE and ST_LOOKUP perform their action on the next clock edge and return unconditionally to ST_IDLE. A one-cycle done pulse follows that edge.

Top module: `tlb_test_port`

## Requirements
- R1: After reset the data register reads 0, done is low, every entry is invalid and every tree is 000, so any lookup misses.
- R2: Writing the data register loads all 32 bits and starts nothing: done stays low and the table does not change.
- R3: On a test write with data bit 4 = 1, the entry goes into the way given by data bits 3:2.
- R4: On a test write with data bit 4 = 0, the lowest-numbered invalid way of the set is filled.
- R5: On a test write with data bit 4 = 0 and all four ways valid, the victim follows the tree. Tree bit 0 = 0 selects ways {0,1}, where tree bit 1 picks way 1 when set and way 0 otherwise. Tree bit 0 = 1 selects ways {2,3}, where tree bit 2 picks way 3 when set and way 2 otherwise. The replaced tag then misses.
- R6: Every test write, whatever the pointer source, marks the written way most recently used. For ways 0 and 1, tree bit 0 becomes 1 and tree bit 1 becomes the inverse of way bit 0. For ways 2 and 3, tree bit 0 becomes 0 and tree bit 2 becomes the inverse of way bit 0.
- R7: A lookup hit writes the following into the data register. Bits 31:12 hold the stored page number, bit 11 the cache-disable attribute and bit 10 the write-through attribute. Bits 9:7 hold the set's tree as it stood before the lookup, with bit 7 as tree bit 0. Bit 4 becomes 1 and bits 3:2 hold the hit way. Bits 6:5 and 1:0 keep their previous values.
- R8: A lookup hit marks the hit way most recently used, using the same rule as R6.
- R9: A lookup miss clears data bit 4 and leaves data bits 31:5 and the tree unchanged.
- R10: On a test write, data bits 9:7 are ignored. The tree a later lookup reports depends only on past accesses.
- R11: The command word holds the linear page address in bits 31:12, the valid flag in bit 11 and the operation in bit 0 (0 = write, 1 = lookup). The set index is linear bits 14:12, and bits 31:15 form the tag. The operation executes on the edge after the command write, and done is high for exactly the following cycle.
- R12: A test write with the valid flag at 0 invalidates the chosen way, so a later lookup of that tag misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_i | input | 1 | Write strobe for the command register (starts an operation) |
| data_wr_i | input | 1 | Write strobe for the data register |
| wdata_i | input | 32 | Write data for either register |
| cmd_o | output | 32 | Command register contents |
| data_o | output | 32 | Data register contents |
| done_o | output | 1 | One-cycle pulse after an operation completes |

## Verification
The assertions assume three things about the host. No set ever holds the same valid tag in more than one way, since the hit encoder and the one-hot hit check depend on that. No command write arrives while an operation is in flight. No data-register write coincides with a lookup's result cycle. The directed stimulus gives every entry a different tag within its set. It also waits for each done pulse and the idle cycle after it before touching either register again. Invalidation targets the way that already holds the same tag, so no duplicate can arise.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    typedef logic [2:0] plru_t;

    typedef struct packed {
        logic [19:0] ppn;
        logic        pcd;
        logic        pwt;
    } tlb_data_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_LOOKUP = 2'd2
    } seq_state_e;

    // Follow the tree to the least recently used way.
    function automatic logic [WAY_W-1:0] plru_victim(plru_t t);
        if (t[0]) return t[2] ? 2'd3 : 2'd2;
        else      return t[1] ? 2'd1 : 2'd0;
    endfunction

    // Point every node on the path away from the accessed way.
    function automatic plru_t plru_touch(plru_t t, logic [WAY_W-1:0] w);
        plru_t r;
        r = t;
        if (!w[1]) begin
            r[0] = 1'b1;
            r[1] = ~w[0];
        end else begin
            r[0] = 1'b0;
            r[2] = ~w[0];
        end
        return r;
    endfunction

endpackage

// File: rtl/tlb_plru.sv
module tlb_plru
    import tlb_pkg::*;
#(
    parameter int NUM_SETS = 8,
    localparam int IDX_W = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_i,
    input  logic             upd_en_i,
    input  logic [WAY_W-1:0] upd_way_i,
    output plru_t            tree_o
);

    plru_t lru_q [NUM_SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) lru_q[s] <= '0;
        end else if (upd_en_i) begin
            lru_q[set_i] <= plru_touch(lru_q[set_i], upd_way_i);
        end
    end

    assign tree_o = lru_q[set_i];

    // R6 / R8: the way just accessed is never the next tree victim
    assert_mru_not_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en_i |=> plru_victim(lru_q[$past(set_i)]) != $past(upd_way_i));

    // R9: without an update the set's tree is held
    assert_tree_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en_i |=> lru_q[$past(set_i)] == $past(tree_o));

endmodule

// File: rtl/tlb_ways.sv
module tlb_ways
    import tlb_pkg::*;
#(
    parameter int NUM_SETS = 8,
    localparam int IDX_W = $clog2(NUM_SETS),
    localparam int TAG_W = 20 - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             wr_en_i,
    input  logic [WAY_W-1:0] wr_way_i,
    input  logic             wr_valid_i,
    input  tlb_data_t        wr_data_i,
    output logic [WAYS-1:0]  valid_vec_o,
    output logic             hit_o,
    output logic [WAY_W-1:0] hit_way_o,
    output tlb_data_t        hit_data_o
);

    logic [WAYS-1:0] hit_vec;
    tlb_data_t       way_data [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic             v_q   [NUM_SETS];
        logic [TAG_W-1:0] tag_q [NUM_SETS];
        tlb_data_t        dat_q [NUM_SETS];
        logic             sel;

        assign sel = wr_en_i && (wr_way_i == WAY_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < NUM_SETS; s++) v_q[s] <= 1'b0;
            end else if (sel) begin
                v_q[set_i] <= wr_valid_i;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[set_i] <= tag_i;
                dat_q[set_i] <= wr_data_i;
            end
        end

        assign valid_vec_o[w] = v_q[set_i];
        assign hit_vec[w]     = v_q[set_i] && (tag_q[set_i] == tag_i);
        assign way_data[w]    = dat_q[set_i];
    end

    always_comb begin
        hit_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way_o = WAY_W'(w);
        end
    end

    assign hit_o      = |hit_vec;
    assign hit_data_o = way_data[hit_way_o];

    // R7: a set never matches a tag in more than one way
    assert_single_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R12: a write leaves the chosen way's valid bit equal to the flag written
    assert_valid_written_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (valid_vec_o[$past(wr_way_i)] == $past(wr_valid_i))
                    || ($past(set_i) != set_i));

endmodule

// File: rtl/tlb_seq.sv
module tlb_seq
    import tlb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr_i,
    input  logic       op_lookup_i,
    output seq_state_e state_o,
    output logic       do_write_o,
    output logic       do_lookup_o,
    output logic       done_o
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_o  <= (state_q != ST_IDLE);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_wr_i) state_d = op_lookup_i ? ST_LOOKUP : ST_WRITE;
            ST_WRITE:  state_d = ST_IDLE;
            ST_LOOKUP: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        do_write_o  = 1'b0;
        do_lookup_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_WRITE:  do_write_o  = 1'b1;
            ST_LOOKUP: do_lookup_o = 1'b1;
            default:   ;
        endcase
    end

    assign state_o = state_q;

    // R11: a command write in idle starts an operation
    assert_cmd_starts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_wr_i) |=> state_q != ST_IDLE);

    // R11: an operation occupies a single cycle
    assert_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> state_q == ST_IDLE);

    // R11: done is a single-cycle pulse
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/tlb_test_port.sv
module tlb_test_port
    import tlb_pkg::*;
#(
    parameter int NUM_SETS = 8,
    localparam int IDX_W = $clog2(NUM_SETS),
    localparam int TAG_W = 20 - IDX_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr_i,
    input  logic        data_wr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] cmd_o,
    output logic [31:0] data_o,
    output logic        done_o
);

    logic [31:0]      cmd_q, data_q;
    seq_state_e       state;
    logic             do_write, do_lookup;
    logic [IDX_W-1:0] set_idx;
    logic [TAG_W-1:0] tag;
    logic [WAYS-1:0]  valid_vec;
    logic             hit;
    logic [WAY_W-1:0] hit_way, first_inv, wr_way, upd_way;
    tlb_data_t        hit_data, wr_data;
    plru_t            tree;
    logic             upd_en;

    tlb_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr_i    (cmd_wr_i),
        .op_lookup_i (wdata_i[0]),
        .state_o     (state),
        .do_write_o  (do_write),
        .do_lookup_o (do_lookup),
        .done_o      (done_o)
    );

    // Register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_wr_i && state == ST_IDLE) begin
            cmd_q <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (do_lookup) begin
            if (hit) data_q <= {hit_data.ppn, hit_data.pcd, hit_data.pwt, tree,
                                data_q[6:5], 1'b1, hit_way, data_q[1:0]};
            else     data_q[4] <= 1'b0;
        end else if (data_wr_i) begin
            data_q <= wdata_i;
        end
    end

    assign set_idx = cmd_q[12 +: IDX_W];
    assign tag     = cmd_q[31 -: TAG_W];
    assign wr_data = '{ppn: data_q[31:12], pcd: data_q[11], pwt: data_q[10]};

    // Replacement pointer
    always_comb begin
        first_inv = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) first_inv = WAY_W'(w);
        end
    end

    always_comb begin
        if (data_q[4])        wr_way = data_q[3:2];
        else if (&valid_vec)  wr_way = plru_victim(tree);
        else                  wr_way = first_inv;
    end

    assign upd_en  = do_write || (do_lookup && hit);
    assign upd_way = do_write ? wr_way : hit_way;

    tlb_ways #(.NUM_SETS(NUM_SETS)) u_ways (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (set_idx),
        .tag_i       (tag),
        .wr_en_i     (do_write),
        .wr_way_i    (wr_way),
        .wr_valid_i  (cmd_q[11]),
        .wr_data_i   (wr_data),
        .valid_vec_o (valid_vec),
        .hit_o       (hit),
        .hit_way_o   (hit_way),
        .hit_data_o  (hit_data)
    );

    tlb_plru #(.NUM_SETS(NUM_SETS)) u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_idx),
        .upd_en_i  (upd_en),
        .upd_way_i (upd_way),
        .tree_o    (tree)
    );

    assign cmd_o  = cmd_q;
    assign data_o = data_q;

    // R2: the data register changes only by a host write or a lookup
    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_wr_i && !do_lookup) |=> $stable(data_q));

    // R9: a miss clears the hit flag and keeps bits 31:5
    assert_miss_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (do_lookup && !hit) |=> !data_q[4] && data_q[31:5] == $past(data_q[31:5]));

    // R7: a hit reports the flag and the way that matched
    assert_hit_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_lookup && hit) |=> data_q[4] && data_q[3:2] == $past(hit_way));

    // R3: an explicit pointer decides the written way
    assert_explicit_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && data_q[4]) |-> wr_way == data_q[3:2]);

endmodule

// File: tb/tb_tlb_test_port.sv
module tb_tlb_test_port;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_wr_i, data_wr_i;
    logic [31:0] wdata_i;
    logic [31:0] cmd_o, data_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tlb_test_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr_i  (cmd_wr_i),
        .data_wr_i (data_wr_i),
        .wdata_i   (wdata_i),
        .cmd_o     (cmd_o),
        .data_o    (data_o),
        .done_o    (done_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr_data(logic [31:0] v);
        data_wr_i = 1'b1;
        wdata_i   = v;
        @(negedge clk);
        data_wr_i = 1'b0;
        chk("R2 data load", data_o, v);
    endtask

    task automatic run_cmd(logic [16:0] tag, logic [2:0] set, logic vld, logic op);
        cmd_wr_i = 1'b1;
        wdata_i  = {tag, set, vld, 10'b0, op};
        @(negedge clk);
        cmd_wr_i = 1'b0;
        chk("R11 command register", cmd_o, {tag, set, vld, 10'b0, op});
        chk("R11 done low while busy", {31'b0, done_o}, 32'd0);
        @(negedge clk);
        chk("R11 done pulse", {31'b0, done_o}, 32'd1);
        @(negedge clk);
        chk("R11 done ends", {31'b0, done_o}, 32'd0);
    endtask

    task automatic do_write(logic [16:0] tag, logic [2:0] set, logic [31:0] d, logic vld);
        wr_data(d);
        run_cmd(tag, set, vld, 1'b0);
    endtask

    task automatic expect_hit(string req, logic [16:0] tag, logic [2:0] set,
                              logic [31:0] stored, logic [2:0] lru, logic [1:0] way);
        logic [31:0] pre;
        pre = data_o;
        run_cmd(tag, set, 1'b1, 1'b1);
        chk(req, data_o, {stored[31:10], lru, pre[6:5], 1'b1, way, pre[1:0]});
    endtask

    task automatic expect_miss(string req, logic [16:0] tag, logic [2:0] set);
        logic [31:0] pre;
        pre = data_o;
        run_cmd(tag, set, 1'b1, 1'b1);
        chk(req, data_o, pre & ~32'h10);
    endtask

    task automatic t_reset;
        chk("R1 data after reset", data_o, 32'd0);
        chk("R1 done after reset", {31'b0, done_o}, 32'd0);
        expect_miss("R1 empty table misses", 17'h00011, 3'd1);
    endtask

    task automatic t_data_only;
        wr_data(32'hCAFE_0C1C);
        repeat (3) begin
            @(negedge clk);
            chk("R2 no done on data write", {31'b0, done_o}, 32'd0);
            chk("R2 data held", data_o, 32'hCAFE_0C1C);
        end
        expect_miss("R9 miss keeps 31:5, clears bit4", 17'h00001, 3'd3);
        chk("R9 miss value", data_o, 32'hCAFE_0C0C);
    endtask

    task automatic t_lru_fill;
        do_write(17'h00011, 3'd1, 32'hA000_1C00, 1'b1);
        do_write(17'h00022, 3'd1, 32'hB000_2400, 1'b1);
        do_write(17'h00033, 3'd1, 32'hC000_3800, 1'b1);
        do_write(17'h00044, 3'd1, 32'hD000_4000, 1'b1);
        // R4: invalid-first order filled ways 0..3; tree now 000
        expect_hit("R4 first fill way0, R7 fields", 17'h00011, 3'd1, 32'hA000_1C00, 3'b000, 2'd0);
        // R8: hit on way0 made tree 011
        expect_hit("R8 hit updates tree, R4 way2", 17'h00033, 3'd1, 32'hC000_3800, 3'b011, 2'd2);
        // R5: tree 110 -> victim way1; R10: data bits 9:7 = 111 ignored
        do_write(17'h00055, 3'd1, 32'hE000_5F80, 1'b1);
        expect_hit("R5 tree victim way1, R6/R10 tree 101", 17'h00055, 3'd1, 32'hE000_5F80, 3'b101, 2'd1);
        expect_miss("R5 replaced tag misses", 17'h00022, 3'd1);
        expect_hit("R9 miss left tree 101", 17'h00044, 3'd1, 32'hD000_4000, 3'b101, 2'd3);
    endtask

    task automatic t_explicit_ptr;
        // R3: bit4=1, ptr=2, bits 9:7 = 111 (ignored by R10)
        do_write(17'h00066, 3'd2, 32'hF000_6398, 1'b1);
        expect_hit("R3 explicit way2, R6/R10 tree 100", 17'h00066, 3'd2, 32'hF000_6398, 3'b100, 2'd2);
        do_write(17'h00077, 3'd2, 32'h1234_5800, 1'b1);
        expect_hit("R4 invalid way0 chosen, R6 tree 111", 17'h00077, 3'd2, 32'h1234_5800, 3'b111, 2'd0);
    endtask

    task automatic t_invalidate;
        do_write(17'h00077, 3'd2, 32'h0000_0010, 1'b0);
        expect_miss("R12 invalidated tag misses", 17'h00077, 3'd2);
        expect_hit("R12 other way still hits", 17'h00066, 3'd2, 32'hF000_6398, 3'b111, 2'd2);
    endtask

    initial begin
        rst_n     = 1'b0;
        cmd_wr_i  = 1'b0;
        data_wr_i = 1'b0;
        wdata_i   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_only();
        t_lru_fill();
        t_explicit_ptr();
        t_invalidate();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule